// File: doc/BRIEF.md
# Capture and Match Timer

This block is a free-running up-counter that advances by one on every clock where the count-enable tick is high. It watches a raw external input and stores the current count in a capture register when a chosen edge arrives. It also compares the count with a programmable match value. Each of these two events sets its own sticky flag. Software clears a flag by writing a one to its bit.

Each flag can raise a request for service. One steering bit sends every enabled request either to a level interrupt line or to a level DMA request line. The reference request has an enable of its own. Software programs the block through a small word-wide register port, and read data comes back one clock after the address.

Top module: `capref_timer`

## Requirements
- R1: All state is cleared by a synchronous active-high reset: counter, mode, match value, capture value and both flags are zero, and both request outputs are low.
- R2: The counter increments by one, modulo 2^32, on each clock edge where `tick_i` is high, and holds otherwise.
- R3: Capture mode is mode register bits [1:0]. The encoding is 00 off, 01 rising edge, 10 falling edge, 11 both edges. In mode 00 no capture takes place and the capture register holds its value.
- R4: An enabled edge on `cap_i` is captured on the third clock edge after the input changes. On that edge the capture register takes the counter value present just before the edge, and the capture flag (event bit 0) sets.
- R5: The match flag (event bit 1) sets on the tick edge that makes the counter equal to the match register.
- R6: The event register is at address 3. Bits 7 through 2 of that register, and all bits above them, read as zero.
- R7: Writing 1 to an event bit clears that flag. Writing 0 leaves it unchanged.
- R8: If a clear and a new event hit the same flag in the same cycle, the flag stays set.
- R9: The capture request is active while the capture flag is set and the capture mode is not 00. It drives `irq_o` when mode bit 3 (DMA steer) is 0 and `dma_o` when that bit is 1.
- R10: The match request is active while the match flag is set and mode bit 2 (match request enable) is 1, and it is steered by mode bit 3 in the same way as R9. With bit 2 at 0, a match raises no request.
- R11: Both request outputs are registered. They rise one clock after the flag sets, fall one clock after the flag clears, and are never high together.
- R12: The register map is: address 0 mode (bits [3:0]), address 1 match value, address 2 capture value (read-only), address 3 events. Read data appears one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-enable tick |
| cap_i | input | 1 | Raw asynchronous capture input |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt request |
| dma_o | output | 1 | Level DMA request |

## Verification
Two things can reach the same flag in one cycle: a software clear of the flag and a fresh capture or match event. The bench sets up both cases. For a capture, it times the event-register write to land on the third clock after the capture input changes. For a match, it drives the last tick in the same cycle as the clear write. A correct design keeps the flag set in both cases, so a later read of the event register must still show the bit.

// File: rtl/capref_pkg.sv
package capref_pkg;
  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADR_MODE  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_MATCH = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_CAPT  = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADR_EVT   = 2'd3;

  localparam int EVB_CAP   = 0;
  localparam int EVB_MATCH = 1;
  localparam int EV_W      = 2;
  localparam int MODE_W    = 4;

  typedef enum logic [1:0] {
    CAPM_OFF  = 2'b00,
    CAPM_RISE = 2'b01,
    CAPM_FALL = 2'b10,
    CAPM_BOTH = 2'b11
  } capm_e;

  typedef struct packed {
    logic  dma_steer;
    logic  match_req_en;
    capm_e capm;
  } mode_t;
endpackage

// File: rtl/capref_sync_edge.sv
module capref_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] stage_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= 1'b0;
        else     stage_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= 1'b0;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= stage_q[STAGES-1];
  end

  assign rise_o =  stage_q[STAGES-1] & ~last_q;
  assign fall_o = ~stage_q[STAGES-1] &  last_q;
endmodule

// File: rtl/capref_counter.sv
module capref_counter
  import capref_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  capm_e            capm_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_evt_o,
  output logic             match_evt_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_nx;

  assign count_nx = count_q + CNT_W'(1);

  always_comb begin
    unique case (capm_i)
      CAPM_RISE: cap_evt_o = rise_i;
      CAPM_FALL: cap_evt_o = fall_i;
      CAPM_BOTH: cap_evt_o = rise_i | fall_i;
      default:   cap_evt_o = 1'b0;
    endcase
  end

  assign match_evt_o = tick_i && (count_nx == match_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      cap_val_o <= '0;
    end else begin
      if (tick_i)    count_q   <= count_nx;
      if (cap_evt_o) cap_val_o <= count_q;
    end
  end

  // R3
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (capm_i == CAPM_OFF) |=> $stable(cap_val_o));
endmodule

// File: rtl/capref_flags.sv
module capref_flags
  import capref_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_evt_i,
  input  logic            match_evt_i,
  input  logic [EV_W-1:0] clr_i,
  input  logic            cap_req_en_i,
  input  logic            match_req_en_i,
  input  logic            dma_steer_i,
  output logic [EV_W-1:0] flags_o,
  output logic            irq_o,
  output logic            dma_o
);
  logic [EV_W-1:0] set_v;
  logic [EV_W-1:0] en_v;
  logic            want;

  assign set_v[EVB_CAP]   = cap_evt_i;
  assign set_v[EVB_MATCH] = match_evt_i;
  assign en_v[EVB_CAP]    = cap_req_en_i;
  assign en_v[EVB_MATCH]  = match_req_en_i;
  assign want             = |(flags_o & en_v);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      irq_o   <= 1'b0;
      dma_o   <= 1'b0;
    end else begin
      flags_o <= set_v | (flags_o & ~clr_i);
      irq_o   <= want & ~dma_steer_i;
      dma_o   <= want &  dma_steer_i;
    end
  end

  // R4
  cap_set_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt_i |=> flags_o[EVB_CAP]);
  // R5
  match_set_chk: assert property (@(posedge clk) disable iff (rst)
    match_evt_i |=> flags_o[EVB_MATCH]);
  // R7
  cap_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i[EVB_CAP] && !cap_evt_i) |=> !flags_o[EVB_CAP]);
  // R11
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && dma_o));
  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|flags_o));
endmodule

// File: rtl/capref_timer.sv
module capref_timer
  import capref_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_i,
  input  logic                  cap_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  wr_en_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  irq_o,
  output logic                  dma_o
);
  localparam int CNT_W = DATA_W;

  mode_t            mode_q;
  logic [CNT_W-1:0] match_q;
  logic [CNT_W-1:0] cap_val;
  logic             rise, fall, cap_evt, match_evt;
  logic [EV_W-1:0]  flags, clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      match_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADR_MODE)  mode_q  <= mode_t'(wr_data_i[MODE_W-1:0]);
      if (addr_i == ADR_MATCH) match_q <= wr_data_i;
    end
  end

  assign clr = (wr_en_i && addr_i == ADR_EVT) ? wr_data_i[EV_W-1:0] : '0;

  capref_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(cap_i), .rise_o(rise), .fall_o(fall)
  );

  capref_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i), .capm_i(mode_q.capm),
    .rise_i(rise), .fall_i(fall), .match_i(match_q),
    .cap_val_o(cap_val), .cap_evt_o(cap_evt), .match_evt_o(match_evt)
  );

  capref_flags u_flags (
    .clk(clk), .rst(rst), .cap_evt_i(cap_evt), .match_evt_i(match_evt),
    .clr_i(clr), .cap_req_en_i(mode_q.capm != CAPM_OFF),
    .match_req_en_i(mode_q.match_req_en), .dma_steer_i(mode_q.dma_steer),
    .flags_o(flags), .irq_o(irq_o), .dma_o(dma_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else begin
      unique case (addr_i)
        ADR_MODE:  rd_data_o <= {{(DATA_W-MODE_W){1'b0}}, mode_q};
        ADR_MATCH: rd_data_o <= match_q;
        ADR_CAPT:  rd_data_o <= cap_val;
        default:   rd_data_o <= {{(DATA_W-EV_W){1'b0}}, flags};
      endcase
    end
  end

  // R6
  evt_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_i == ADR_EVT) |=> (rd_data_o[DATA_W-1:EV_W] == '0));
endmodule

// File: tb/capref_timer_test.sv
module capref_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        cap_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o, dma_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] cnt = '0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  capref_timer uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .cap_i(cap_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o), .dma_o(dma_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic ticks(int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
    cnt = cnt + n;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 dma", {31'b0, dma_o}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], rv);
      chk("R1 reg", rv, 0);
    end
  endtask

  task automatic t_rise;
    wr(2'd0, 32'h1);
    rd(2'd0, rv); chk("R12 mode readback", rv, 32'h1);
    ticks(5);
    cap_i = 1'b1;
    idle(3);
    chk("R4 latency irq low after 3", {31'b0, irq_o}, 0);
    idle(1);
    chk("R9 irq after capture", {31'b0, irq_o}, 1);
    chk("R9 dma low", {31'b0, dma_o}, 0);
    rd(2'd2, rv); chk("R2 R4 capture value", rv, cnt);
    rd(2'd3, rv); chk("R4 cap flag", rv, 32'h1);
    wr(2'd3, 32'h0);
    rd(2'd3, rv); chk("R7 write 0 keeps", rv, 32'h1);
    wr(2'd3, 32'hFFFF_FFFD);
    chk("R11 irq held one cycle", {31'b0, irq_o}, 1);
    idle(1);
    chk("R11 irq drops", {31'b0, irq_o}, 0);
    rd(2'd3, rv); chk("R7 w1c clears", rv, 32'h0);
  endtask

  task automatic t_fall;
    logic [31:0] snap;
    wr(2'd0, 32'h2);
    ticks(3);
    cap_i = 1'b0;
    idle(4);
    snap = cnt;
    rd(2'd2, rv); chk("R3 falling capture", rv, snap);
    wr(2'd3, 32'h1);
    ticks(2);
    cap_i = 1'b1;
    idle(5);
    rd(2'd3, rv); chk("R3 rise ignored in fall mode", rv, 0);
    rd(2'd2, rv); chk("R3 capture kept", rv, snap);
    chk("R9 no irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_both_dma;
    wr(2'd0, 32'hB);
    ticks(2);
    cap_i = 1'b0;
    idle(4);
    chk("R9 dma on capture", {31'b0, dma_o}, 1);
    chk("R9 irq low when steered", {31'b0, irq_o}, 0);
    rd(2'd2, rv); chk("R3 both-edge fall capture", rv, cnt);
    wr(2'd3, 32'h1);
    ticks(1);
    cap_i = 1'b1;
    idle(4);
    rd(2'd2, rv); chk("R3 both-edge rise capture", rv, cnt);
    wr(2'd3, 32'h1);
    idle(1);
    chk("R11 dma drops", {31'b0, dma_o}, 0);
  endtask

  task automatic t_off;
    logic [31:0] snap;
    rd(2'd2, snap);
    wr(2'd0, 32'h0);
    ticks(2);
    cap_i = 1'b0; idle(3);
    cap_i = 1'b1; idle(5);
    rd(2'd3, rv); chk("R3 off no event", rv, 0);
    rd(2'd2, rv); chk("R3 off capture held", rv, snap);
    chk("R9 off no irq", {31'b0, irq_o}, 0);
    chk("R9 off no dma", {31'b0, dma_o}, 0);
  endtask

  task automatic t_match;
    wr(2'd0, 32'h4);
    wr(2'd1, cnt + 3);
    ticks(2);
    rd(2'd3, rv); chk("R5 no match yet", rv, 0);
    ticks(1);
    rd(2'd3, rv); chk("R5 match flag", rv, 32'h2);
    chk("R10 match irq", {31'b0, irq_o}, 1);
    wr(2'd3, 32'h2);
    idle(1);
    wr(2'd0, 32'h0);
    wr(2'd1, cnt + 2);
    ticks(2);
    rd(2'd3, rv); chk("R5 match flag, req off", rv, 32'h2);
    chk("R10 no irq when disabled", {31'b0, irq_o}, 0);
    chk("R10 no dma when disabled", {31'b0, dma_o}, 0);
    wr(2'd0, 32'hC);
    idle(1);
    chk("R10 dma steered", {31'b0, dma_o}, 1);
    chk("R10 irq low steered", {31'b0, irq_o}, 0);
    wr(2'd3, 32'h2);
    idle(1);
    chk("R11 match dma drops", {31'b0, dma_o}, 0);
  endtask

  task automatic t_collide;
    wr(2'd0, 32'h1);
    cap_i = 1'b0; idle(4);
    wr(2'd3, 32'h3);
    rd(2'd3, rv); chk("R7 flags clear before", rv, 0);
    cap_i = 1'b1;
    idle(2);
    wr(2'd3, 32'h1);
    rd(2'd3, rv); chk("R8 capture beats clear", rv, 32'h1);
    wr(2'd3, 32'h1);
    wr(2'd1, cnt + 1);
    addr_i = 2'd3; wr_data_i = 32'h2; wr_en_i = 1'b1; tick_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0; wr_data_i = '0;
    cnt = cnt + 1;
    rd(2'd3, rv); chk("R8 match beats clear", rv, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rise();
    t_fall();
    t_both_dma();
    t_off();
    t_match();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule